// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block gathers interrupt events from a parameterized set of sources and decides when a small processor should take one. Each source has three pieces of state: a pending flag that its event sets, an enable bit, and a two-bit priority level. A source takes part in arbitration only while its flag and its enable bit are both set and its level is not the masked value 3. Among the sources that take part, the lowest level wins. On a tie, the lowest source index wins. The block shows the winner's index and level at its outputs at all times.

The block also holds the processor's current interrupt level and a global enable flag. It raises a request when the global flag is on and the winner's level is strictly lower than the current level. When the processor acknowledges, the current level takes the winner's level, and the previous level and global flag are pushed onto a small stack. A return event pops the stack and restores both. Software reaches the flags, enables, levels and the global flag through a single-cycle write port. Any source that is taking part in arbitration drives a wake-up output for standby, whatever the current level or global flag.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, all flags and enables are 0, all levels are 3, the current level is 3 and the global enable is 0. irq_req and wake are 0, irq_vec is 0 and irq_lvl is 3.
- R2: A write with wr_kind=2 stores wr_val as the level of source wr_src, and a value of 0 is stored as 1. A source at level 3 takes no part in arbitration or wake-up.
- R3: A 1 on evt[i] sets flag i. Source i is active only while flag i is 1, enable i is 1 (set through a write with wr_kind=1 from wr_val[0]), and level i is not 3.
- R4: irq_lvl is the lowest level among active sources, and irq_vec is the lowest index holding that level. With no active source, irq_lvl is 3 and irq_vec is 0.
- R5: irq_req is 1 exactly when an active source exists, irq_lvl is numerically lower than cur_lvl, and gie_o is 1.
- R6: On a clock edge with irq_ack=1, irq_req=1 and reti=0, cur_lvl takes irq_lvl and the old cur_lvl and gie_o are pushed. An irq_ack while irq_req is 0 has no effect.
- R7: Acknowledging does not clear a flag. A write with wr_kind=0 and wr_val[0]=0 clears flag wr_src, and wr_val[0]=1 leaves it unchanged. If an event and a clear hit the same flag in one cycle, the flag ends up set.
- R8: wake is 1 whenever any source is active, independent of gie_o and cur_lvl.
- R9: On reti=1 with a non-empty stack, cur_lvl and gie_o take the most recently pushed values. A reti with an empty stack has no effect.
- R10: A write with wr_kind=3 sets gie_o to wr_val[0]. A pop in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | NSRC | Per-source event pulses that set the flags |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Write target: 0 flag, 1 enable, 2 level, 3 global enable |
| wr_src | input | $clog2(NSRC) | Source index for the write |
| wr_val | input | 2 | Write data |
| irq_ack | input | 1 | Processor accepts the presented request |
| reti | input | 1 | Return from the interrupt handler |
| irq_req | output | 1 | A request may be taken now |
| irq_vec | output | $clog2(NSRC) | Index of the winning source |
| irq_lvl | output | 2 | Level of the winning source |
| cur_lvl | output | 2 | Current interrupt level |
| gie_o | output | 1 | Global interrupt enable |
| wake | output | 1 | Standby wake-up |

## Verification
Every result comes from registers through combinational logic only. A write, event, acknowledge or return applied before a rising edge therefore shows on irq_req, irq_vec, irq_lvl, cur_lvl, gie_o and wake right after that same edge, with no further latency. The bench drives each stimulus on the falling edge. It waits for one rising edge and compares all six outputs a short delay later. The directed reset checks sample the outputs while reset is still asserted and again after release, before any other stimulus arrives.

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl #(
  parameter int NSRC  = 8,
  parameter int DEPTH = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         evt,
  input  logic                    wr_en,
  input  logic [1:0]              wr_kind,
  input  logic [$clog2(NSRC)-1:0] wr_src,
  input  logic [1:0]              wr_val,
  input  logic                    irq_ack,
  input  logic                    reti,
  output logic                    irq_req,
  output logic [$clog2(NSRC)-1:0] irq_vec,
  output logic [1:0]              irq_lvl,
  output logic [1:0]              cur_lvl,
  output logic                    gie_o,
  output logic                    wake
);
  localparam int IW = $clog2(NSRC);
  localparam int SW = $clog2(DEPTH + 1);

  logic [NSRC-1:0] flag, en, act;
  logic [1:0]      lvl [NSRC];
  logic [1:0]      stk_lvl [DEPTH];
  logic            stk_gie [DEPTH];
  logic [SW-1:0]   sp;
  logic [1:0]      best;
  logic [IW-1:0]   win;

  wire do_pop  = reti && (sp != '0);
  wire do_push = irq_ack && irq_req && !reti && (sp != SW'(DEPTH));

  always_comb begin
    for (int i = 0; i < NSRC; i++) act[i] = flag[i] && en[i] && (lvl[i] != 2'd3);
  end

  always_comb begin
    best = 2'd3;
    win  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (act[i] && lvl[i] < best) begin
        best = lvl[i];
        win  = IW'(i);
      end
    end
  end

  assign irq_vec = win;
  assign irq_lvl = best;
  assign irq_req = gie_o && (best != 2'd3) && (best < cur_lvl);
  assign wake    = |act;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      wire hit = wr_en && (wr_src == IW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flag[g] <= 1'b0;
          en[g]   <= 1'b0;
          lvl[g]  <= 2'd3;
        end else begin
          if (evt[g])                                     flag[g] <= 1'b1;
          else if (hit && wr_kind == 2'd0 && !wr_val[0])  flag[g] <= 1'b0;
          if (hit && wr_kind == 2'd1) en[g] <= wr_val[0];
          if (hit && wr_kind == 2'd2) lvl[g] <= (wr_val == 2'd0) ? 2'd1 : wr_val;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_lvl <= 2'd3;
      gie_o   <= 1'b0;
      sp      <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        stk_lvl[i] <= 2'd3;
        stk_gie[i] <= 1'b0;
      end
    end else begin
      if (do_pop) begin
        cur_lvl <= stk_lvl[sp - SW'(1)];
        gie_o   <= stk_gie[sp - SW'(1)];
        sp      <= sp - SW'(1);
      end else begin
        if (wr_en && wr_kind == 2'd3) gie_o <= wr_val[0];
        if (do_push) begin
          stk_lvl[sp] <= cur_lvl;
          stk_gie[sp] <= gie_o;
          cur_lvl     <= best;
          sp          <= sp + SW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_ack,
  input logic       reti,
  input logic       irq_req,
  input logic [1:0] irq_lvl,
  input logic [1:0] cur_lvl,
  input logic       gie_o,
  input logic       wake
);
  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> gie_o); // R5
  AST_REQ_STRICT: assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> (irq_lvl < cur_lvl)); // R5
  AST_ENTRY_LOADS: assert property (@(posedge clk) disable iff (!rst_n) (irq_ack && irq_req && !reti) |=> (cur_lvl == $past(irq_lvl))); // R6
  AST_REQ_WAKES: assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> wake); // R8
  AST_LVL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) cur_lvl != 2'd0); // R2
  AST_LVL_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!irq_ack && !reti) |=> $stable(cur_lvl)); // R9
endmodule

bind irq_level_ctrl irq_level_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .reti(reti), .irq_req(irq_req),
  .irq_lvl(irq_lvl), .cur_lvl(cur_lvl), .gie_o(gie_o), .wake(wake)
);

// File: tb/test_irq_level_ctrl.sv
module test_irq_level_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 23;

  // [27] wr_en [26:25] kind [24:22] src [21:20] val [19:12] evt [11] ack [10] reti
  // [9] req [8:6] vec [5:4] lvl [3:2] cur [1] gie [0] wake
  localparam logic [27:0] VEC [NV] = '{
    {1'b1,2'd3,3'd0,2'd1,8'h00,1'b0,1'b0, 1'b0,3'd0,2'd3,2'd3,1'b1,1'b0},
    {1'b0,2'd0,3'd0,2'd0,8'h04,1'b0,1'b0, 1'b0,3'd0,2'd3,2'd3,1'b1,1'b0},
    {1'b1,2'd1,3'd2,2'd1,8'h00,1'b0,1'b0, 1'b0,3'd0,2'd3,2'd3,1'b1,1'b0},
    {1'b1,2'd2,3'd2,2'd2,8'h00,1'b0,1'b0, 1'b1,3'd2,2'd2,2'd3,1'b1,1'b1},
    {1'b1,2'd1,3'd5,2'd1,8'h20,1'b0,1'b0, 1'b1,3'd2,2'd2,2'd3,1'b1,1'b1},
    {1'b1,2'd2,3'd5,2'd2,8'h00,1'b0,1'b0, 1'b1,3'd2,2'd2,2'd3,1'b1,1'b1},
    {1'b0,2'd0,3'd0,2'd0,8'h00,1'b1,1'b0, 1'b0,3'd2,2'd2,2'd2,1'b1,1'b1},
    {1'b1,2'd2,3'd5,2'd1,8'h00,1'b0,1'b0, 1'b1,3'd5,2'd1,2'd2,1'b1,1'b1},
    {1'b0,2'd0,3'd0,2'd0,8'h00,1'b1,1'b0, 1'b0,3'd5,2'd1,2'd1,1'b1,1'b1},
    {1'b0,2'd0,3'd0,2'd0,8'h00,1'b0,1'b1, 1'b1,3'd5,2'd1,2'd2,1'b1,1'b1},
    {1'b1,2'd0,3'd5,2'd1,8'h00,1'b0,1'b0, 1'b1,3'd5,2'd1,2'd2,1'b1,1'b1},
    {1'b1,2'd0,3'd5,2'd0,8'h00,1'b0,1'b0, 1'b0,3'd2,2'd2,2'd2,1'b1,1'b1},
    {1'b0,2'd0,3'd0,2'd0,8'h00,1'b0,1'b1, 1'b1,3'd2,2'd2,2'd3,1'b1,1'b1},
    {1'b1,2'd3,3'd0,2'd0,8'h00,1'b0,1'b0, 1'b0,3'd2,2'd2,2'd3,1'b0,1'b1},
    {1'b0,2'd0,3'd0,2'd0,8'h00,1'b1,1'b0, 1'b0,3'd2,2'd2,2'd3,1'b0,1'b1},
    {1'b0,2'd0,3'd0,2'd0,8'h00,1'b0,1'b1, 1'b0,3'd2,2'd2,2'd3,1'b0,1'b1},
    {1'b1,2'd2,3'd2,2'd0,8'h00,1'b0,1'b0, 1'b0,3'd2,2'd1,2'd3,1'b0,1'b1},
    {1'b1,2'd3,3'd0,2'd1,8'h00,1'b0,1'b0, 1'b1,3'd2,2'd1,2'd3,1'b1,1'b1},
    {1'b0,2'd0,3'd0,2'd0,8'h00,1'b1,1'b0, 1'b0,3'd2,2'd1,2'd1,1'b1,1'b1},
    {1'b1,2'd3,3'd0,2'd0,8'h00,1'b0,1'b0, 1'b0,3'd2,2'd1,2'd1,1'b0,1'b1},
    {1'b0,2'd0,3'd0,2'd0,8'h00,1'b0,1'b1, 1'b1,3'd2,2'd1,2'd3,1'b1,1'b1},
    {1'b1,2'd0,3'd2,2'd0,8'h04,1'b0,1'b0, 1'b1,3'd2,2'd1,2'd3,1'b1,1'b1},
    {1'b1,2'd2,3'd2,2'd3,8'h00,1'b0,1'b0, 1'b0,3'd0,2'd3,2'd3,1'b1,1'b0}
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 13, 19: return "R10";
      1, 2:      return "R3";
      3, 7:      return "R4";
      4, 22:     return "R2";
      5:         return "R4 tie";
      6, 8, 18:  return "R6";
      9, 12:     return "R9";
      10, 11, 21: return "R7";
      14:        return "R6 ignored ack";
      15:        return "R9 empty";
      16:        return "R2 zero";
      17:        return "R5";
      20:        return "R9 gie";
      default:   return "R8";
    endcase
  endfunction

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_kind = '0;
  logic [2:0] wr_src = '0;
  logic [1:0] wr_val = '0;
  logic       irq_ack = 1'b0;
  logic       reti = 1'b0;
  logic       irq_req;
  logic [2:0] irq_vec;
  logic [1:0] irq_lvl;
  logic [1:0] cur_lvl;
  logic       gie_o;
  logic       wake;
  int checks = 0;
  int fails = 0;

  irq_level_ctrl i_irq_level_ctrl (
    .clk(clk), .rst_n(rst_n), .evt(evt), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_src(wr_src), .wr_val(wr_val), .irq_ack(irq_ack), .reti(reti),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
    .cur_lvl(cur_lvl), .gie_o(gie_o), .wake(wake)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [9:0] outs();
    return {irq_req, irq_vec, irq_lvl, cur_lvl, gie_o, wake};
  endfunction

  task automatic check(input string tag, input logic [9:0] exp);
    checks++;
    if (outs() !== exp) begin
      fails++;
      $display("FAIL %s: got req=%b vec=%0d lvl=%0d cur=%0d gie=%b wake=%b, expected req=%b vec=%0d lvl=%0d cur=%0d gie=%b wake=%b",
               tag, irq_req, irq_vec, irq_lvl, cur_lvl, gie_o, wake,
               exp[9], exp[8:6], exp[5:4], exp[3:2], exp[1], exp[0]);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; evt = '0; irq_ack = 1'b0; reti = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  localparam logic [9:0] RST_OUT = {1'b0, 3'd0, 2'd3, 2'd3, 1'b0, 1'b0};

  initial begin
    #(CLK_PERIOD * 3);
    check("R1 in reset", RST_OUT);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", RST_OUT);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {wr_en, wr_kind, wr_src, wr_val, evt, irq_ack, reti} = VEC[i][27:10];
      @(posedge clk); #1;
      check(tag_of(i), VEC[i][9:0]);
    end
    @(negedge clk) idle();
    // R8: wake with gie off and a pending enabled source
    wr_en = 1'b1; wr_kind = 2'd2; wr_src = 3'd7; wr_val = 2'd2;
    @(negedge clk); wr_en = 1'b0; evt = 8'h80;
    @(negedge clk); wr_en = 1'b1; wr_kind = 2'd1; wr_src = 3'd7; wr_val = 2'd1; evt = '0;
    @(negedge clk); wr_kind = 2'd3; wr_val = 2'd0;
    @(posedge clk); #1;
    check("R8 wake gie off", {1'b0, 3'd7, 2'd2, 2'd3, 1'b0, 1'b1});
    @(negedge clk) idle(); rst_n = 1'b0;
    #1 check("R1 mid-run reset", RST_OUT);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 state cleared", RST_OUT);
    summary();
  end

  initial begin
    #(CLK_PERIOD * 2000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
  end
endmodule